// File: doc/BRIEF.md
# Instruction Cache Line Requester

This block sits between the fetch stage of a multithreaded core and the instruction cache. Every cycle the fetch stage may present one thread's program counter. The block keeps one line buffer per thread, holding the line data, a tag and a valid bit. If that thread's buffer already holds the line that contains the counter, the line is returned as a hit and nothing goes to the cache. Otherwise the block sends a read for the whole line and tracks it until the data arrives.

The cache answers each request in the cycle it is offered. It can grant the request or refuse it. A refused request waits in one retry slot that all threads share, and while it waits no other thread may start a new read. A retry pulse from the cache sends the parked request again. Each request carries a per-thread rolling identifier. A response that does not match the thread's outstanding request, or that reaches a thread which is no longer waiting, is dropped and counted. A squash on a thread makes it forget its outstanding work.

Per-thread state encoding on `thr_state`: 0 running, 1 sending, 2 waiting for retry, 3 waiting for response, 4 line arrived, 5 blocked.

Top module: `icl_line_req`

## Requirements
- R1: A miss produces a request on the cycle after the fetch. The request address is the fetch counter with its low log2(BLK_BYTES) bits cleared. Every counter inside one block maps to the same address.
- R2: A fetch for a thread in state 0, with its stall low, its line valid and its tag equal to the aligned address, is a hit. The next cycle shows `hit_valid`=1, `hit_tid` and the stored line on `hit_line`, and no request is sent.
- R3: Issuing a request sets the thread's tag to the aligned address, clears its line valid bit and moves it to state 1. The request identifier is the thread's issue count modulo 2^RIDW, starting from 0 after reset. After reset no request is pending, no line is valid, every thread is in state 0 and the drop count is 0.
- R4: A request that is not granted in its cycle is parked in the retry slot. `cache_blocked` goes to 1 on the next cycle and the thread moves to state 2.
- R5: While `cache_blocked` is 1, no fetch from any thread starts a new request.
- R6: A `retry_in` pulse while a request is parked sends that request again on the next cycle, with the same thread, address and identifier. Once it is granted, the slot empties, `cache_blocked` drops and the thread moves to state 3.
- R7: A response is discarded unless its thread is in state 3 and its identifier equals that thread's outstanding identifier. A discarded response adds one to `drop_count` and leaves the line buffer unchanged.
- R8: An accepted response writes the line and sets its valid bit. The thread goes to state 5 if its stall is high and to state 4 otherwise. From state 4 it returns to state 0 on the next cycle.
- R9: A squash puts the thread in state 0 and forgets its outstanding request, so a later response for that request is dropped. It empties the retry slot and clears `cache_blocked` only when the parked request belongs to the squashed thread.
- R10: Each request is valid for exactly one cycle, and the grant is sampled in that cycle. Two requests never appear on consecutive cycles.
- R11: A thread in state 0 or 4 whose stall is high moves to state 5. It returns to state 0 on the first cycle its stall is low. Stalls have no effect on states 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch attempt this cycle |
| fetch_tid | input | TIDW | Thread of the fetch attempt |
| fetch_pc | input | AW | Fetch program counter |
| stall | input | NTHR | Per-thread stall from downstream |
| squash_valid | input | 1 | Squash a thread this cycle |
| squash_tid | input | TIDW | Thread being squashed |
| req_valid | output | 1 | Line read offered to the cache (one cycle) |
| req_tid | output | TIDW | Thread of the read |
| req_addr | output | AW | Block-aligned read address |
| req_rid | output | RIDW | Request identifier |
| req_grant | input | 1 | Cache accepts the offered read |
| retry_in | input | 1 | Cache can take a refused read again |
| rsp_valid | input | 1 | Line data returning |
| rsp_tid | input | TIDW | Thread tag of the response |
| rsp_rid | input | RIDW | Identifier tag of the response |
| rsp_data | input | LINE_W | Line data |
| hit_valid | output | 1 | Fetch hit in the line buffer |
| hit_tid | output | TIDW | Thread of the hit |
| hit_line | output | LINE_W | Line data for the hit |
| cache_blocked | output | 1 | Cache refused a read and has not taken it yet |
| drop_count | output | CNTW | Wrapping count of discarded responses |
| thr_state | output | 3*NTHR | Per-thread state, thread t at bits 3t+2..3t |
| line_valid | output | NTHR | Per-thread line valid bits |

## Verification
All results are registered. A fetch, grant, retry, response, stall or squash applied before a rising edge is seen at the outputs straight after that edge. In particular a request appears on the cycle after its fetch or retry, and its grant must be presented in that same cycle. The bench drives stimulus just after a falling edge, and reads every result at the next falling edge, one full edge later. Any grant it gives is driven in the window where the request is visible. The bench predicts each address, identifier, state and drop count arithmetically from the requirements.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic [2:0] {
    TS_RUN    = 3'd0,
    TS_SEND   = 3'd1,
    TS_WRETRY = 3'd2,
    TS_WRSP   = 3'd3,
    TS_DONE   = 3'd4,
    TS_BLOCK  = 3'd5
  } thr_st_t;
endpackage

// File: rtl/icl_tag_match.sv
module icl_tag_match #(
  parameter int NTHR = 2,
  parameter int AW   = 12,
  parameter int OFFW = 3,
  parameter int TIDW = 1
) (
  input  logic [AW-1:0]   fetch_pc,
  input  logic [TIDW-1:0] fetch_tid,
  input  logic [AW-1:0]   tags [NTHR],
  input  logic            lv   [NTHR],
  output logic [AW-1:0]   aligned,
  output logic            hit
);
  localparam logic [AW-1:0] OFF_MASK = AW'((1 << OFFW) - 1);

  always_comb begin
    aligned = fetch_pc & ~OFF_MASK;
    hit     = lv[fetch_tid] && (tags[fetch_tid] == aligned);
  end
endmodule

// File: rtl/icl_retry_slot.sv
module icl_retry_slot #(
  parameter int AW   = 12,
  parameter int TIDW = 1,
  parameter int RIDW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            park,
  input  logic [TIDW-1:0] park_tid,
  input  logic [AW-1:0]   park_addr,
  input  logic [RIDW-1:0] park_rid,
  input  logic            grant_clr,
  input  logic            retry_in,
  input  logic            squash_valid,
  input  logic [TIDW-1:0] squash_tid,
  output logic            slot_valid,
  output logic [TIDW-1:0] slot_tid,
  output logic [AW-1:0]   slot_addr,
  output logic [RIDW-1:0] slot_rid,
  output logic            blocked
);
  logic sq_hit;
  assign sq_hit = squash_valid && slot_valid && (slot_tid == squash_tid);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_tid   <= '0;
      slot_addr  <= '0;
      slot_rid   <= '0;
      blocked    <= 1'b0;
    end else if (park) begin
      slot_valid <= 1'b1;
      slot_tid   <= park_tid;
      slot_addr  <= park_addr;
      slot_rid   <= park_rid;
      blocked    <= 1'b1;
    end else if (grant_clr || sq_hit) begin
      slot_valid <= 1'b0;
      blocked    <= 1'b0;
    end else if (retry_in && !slot_valid) begin
      blocked    <= 1'b0;
    end
  end
endmodule

// File: rtl/icl_line_store.sv
module icl_line_store #(
  parameter int NTHR   = 2,
  parameter int TIDW   = 1,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [TIDW-1:0]   wr_tid,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [TIDW-1:0]   rd_tid,
  output logic [LINE_W-1:0] rd_data
);
  logic [LINE_W-1:0] mem [NTHR];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_tid] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_tid];
  end
endmodule

// File: rtl/icl_line_req.sv
module icl_line_req import icl_pkg::*; #(
  parameter int NTHR      = 2,
  parameter int AW        = 12,
  parameter int BLK_BYTES = 8,
  parameter int RIDW      = 2,
  parameter int CNTW      = 8,
  localparam int TIDW     = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int LINE_W   = BLK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [TIDW-1:0]   fetch_tid,
  input  logic [AW-1:0]     fetch_pc,
  input  logic [NTHR-1:0]   stall,
  input  logic              squash_valid,
  input  logic [TIDW-1:0]   squash_tid,
  output logic              req_valid,
  output logic [TIDW-1:0]   req_tid,
  output logic [AW-1:0]     req_addr,
  output logic [RIDW-1:0]   req_rid,
  input  logic              req_grant,
  input  logic              retry_in,
  input  logic              rsp_valid,
  input  logic [TIDW-1:0]   rsp_tid,
  input  logic [RIDW-1:0]   rsp_rid,
  input  logic [LINE_W-1:0] rsp_data,
  output logic              hit_valid,
  output logic [TIDW-1:0]   hit_tid,
  output logic [LINE_W-1:0] hit_line,
  output logic              cache_blocked,
  output logic [CNTW-1:0]   drop_count,
  output logic [3*NTHR-1:0] thr_state,
  output logic [NTHR-1:0]   line_valid
);
  localparam int OFFW = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;

  thr_st_t         st_q      [NTHR];
  logic [AW-1:0]   tag_q     [NTHR];
  logic            lv_q      [NTHR];
  logic [RIDW-1:0] rid_ctr_q [NTHR];
  logic [RIDW-1:0] out_rid_q [NTHR];

  logic [AW-1:0]   aligned;
  logic            tag_hit;
  logic            slot_valid;
  logic [TIDW-1:0] slot_tid;
  logic [AW-1:0]   slot_addr;
  logic [RIDW-1:0] slot_rid;

  logic fetch_run, do_hit, do_issue, do_resend;
  logic sq_on_req, park, grant_clr, rsp_ok;

  icl_tag_match #(.NTHR(NTHR), .AW(AW), .OFFW(OFFW), .TIDW(TIDW)) u_match (
    .fetch_pc (fetch_pc),
    .fetch_tid(fetch_tid),
    .tags     (tag_q),
    .lv       (lv_q),
    .aligned  (aligned),
    .hit      (tag_hit)
  );

  always_comb begin
    fetch_run = fetch_valid && (st_q[fetch_tid] == TS_RUN) && !stall[fetch_tid]
                && !(squash_valid && (squash_tid == fetch_tid));
    do_hit    = fetch_run && tag_hit;
    do_issue  = fetch_run && !tag_hit && !cache_blocked && !req_valid;
    do_resend = retry_in && slot_valid && !req_valid;
    sq_on_req = req_valid && squash_valid && (squash_tid == req_tid);
    park      = req_valid && !req_grant && !sq_on_req;
    grant_clr = req_valid && req_grant;
    rsp_ok    = rsp_valid && (st_q[rsp_tid] == TS_WRSP)
                && (rsp_rid == out_rid_q[rsp_tid])
                && !(squash_valid && (squash_tid == rsp_tid));
  end

  icl_retry_slot #(.AW(AW), .TIDW(TIDW), .RIDW(RIDW)) u_slot (
    .clk         (clk),
    .rst         (rst),
    .park        (park),
    .park_tid    (req_tid),
    .park_addr   (req_addr),
    .park_rid    (req_rid),
    .grant_clr   (grant_clr),
    .retry_in    (retry_in),
    .squash_valid(squash_valid),
    .squash_tid  (squash_tid),
    .slot_valid  (slot_valid),
    .slot_tid    (slot_tid),
    .slot_addr   (slot_addr),
    .slot_rid    (slot_rid),
    .blocked     (cache_blocked)
  );

  icl_line_store #(.NTHR(NTHR), .TIDW(TIDW), .LINE_W(LINE_W)) u_store (
    .clk    (clk),
    .wr_en  (rsp_ok),
    .wr_tid (rsp_tid),
    .wr_data(rsp_data),
    .rd_en  (do_hit),
    .rd_tid (fetch_tid),
    .rd_data(hit_line)
  );

  // Request port, hit flag and drop counter
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_tid    <= '0;
      req_addr   <= '0;
      req_rid    <= '0;
      hit_valid  <= 1'b0;
      hit_tid    <= '0;
      drop_count <= '0;
    end else begin
      req_valid <= do_issue || do_resend;
      if (do_issue) begin
        req_tid  <= fetch_tid;
        req_addr <= aligned;
        req_rid  <= rid_ctr_q[fetch_tid];
      end else if (do_resend) begin
        req_tid  <= slot_tid;
        req_addr <= slot_addr;
        req_rid  <= slot_rid;
      end
      hit_valid <= do_hit;
      if (do_hit) hit_tid <= fetch_tid;
      if (rsp_valid && !rsp_ok) drop_count <= drop_count + CNTW'(1);
    end
  end

  // Per-thread state, tag, valid bit and identifiers
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    localparam logic [TIDW-1:0] TID = TIDW'(t);
    logic sq_t, issue_t, rsp_t, req_t;
    assign sq_t    = squash_valid && (squash_tid == TID);
    assign issue_t = do_issue && (fetch_tid == TID);
    assign rsp_t   = rsp_ok && (rsp_tid == TID);
    assign req_t   = req_valid && (req_tid == TID);

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[t]      <= TS_RUN;
        tag_q[t]     <= '0;
        lv_q[t]      <= 1'b0;
        rid_ctr_q[t] <= '0;
        out_rid_q[t] <= '0;
      end else begin
        if (issue_t) begin
          tag_q[t]     <= aligned;
          lv_q[t]      <= 1'b0;
          rid_ctr_q[t] <= rid_ctr_q[t] + RIDW'(1);
          out_rid_q[t] <= rid_ctr_q[t];
        end else if (rsp_t) begin
          lv_q[t] <= 1'b1;
        end

        if (sq_t) begin
          st_q[t] <= TS_RUN;
        end else begin
          unique case (st_q[t])
            TS_RUN: begin
              if (stall[t])     st_q[t] <= TS_BLOCK;
              else if (issue_t) st_q[t] <= TS_SEND;
            end
            TS_SEND: begin
              if (req_t) st_q[t] <= req_grant ? TS_WRSP : TS_WRETRY;
            end
            TS_WRETRY: begin
              if (req_t && req_grant) st_q[t] <= TS_WRSP;
            end
            TS_WRSP: begin
              if (rsp_t) st_q[t] <= stall[t] ? TS_BLOCK : TS_DONE;
            end
            TS_DONE:  st_q[t] <= stall[t] ? TS_BLOCK : TS_RUN;
            TS_BLOCK: if (!stall[t]) st_q[t] <= TS_RUN;
            default:  st_q[t] <= TS_RUN;
          endcase
        end
      end
    end

    assign thr_state[3*t +: 3] = st_q[t];
    assign line_valid[t]       = lv_q[t];
  end
endmodule

// File: rtl/icl_line_req_chk.sv
module icl_line_req_chk #(
  parameter int NTHR      = 2,
  parameter int AW        = 12,
  parameter int BLK_BYTES = 8,
  parameter int RIDW      = 2,
  parameter int CNTW      = 8,
  localparam int TIDW     = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int LINE_W   = BLK_BYTES * 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [TIDW-1:0]   fetch_tid,
  input logic [AW-1:0]     fetch_pc,
  input logic [NTHR-1:0]   stall,
  input logic              squash_valid,
  input logic [TIDW-1:0]   squash_tid,
  input logic              req_valid,
  input logic [TIDW-1:0]   req_tid,
  input logic [AW-1:0]     req_addr,
  input logic [RIDW-1:0]   req_rid,
  input logic              req_grant,
  input logic              retry_in,
  input logic              rsp_valid,
  input logic [TIDW-1:0]   rsp_tid,
  input logic [RIDW-1:0]   rsp_rid,
  input logic [LINE_W-1:0] rsp_data,
  input logic              hit_valid,
  input logic [TIDW-1:0]   hit_tid,
  input logic [LINE_W-1:0] hit_line,
  input logic              cache_blocked,
  input logic [CNTW-1:0]   drop_count,
  input logic [3*NTHR-1:0] thr_state,
  input logic [NTHR-1:0]   line_valid
);
  localparam int OFFW = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;

  a_r1_block_aligned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[OFFW-1:0] == '0));

  a_r4_refusal_blocks: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_grant && !(squash_valid && squash_tid == req_tid)) |=> cache_blocked);

  a_r5_no_fresh_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (cache_blocked && !retry_in) |=> !req_valid);

  a_r6_grant_unblocks: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_grant) |=> !cache_blocked);

  a_r7_stray_rsp_counted: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && thr_state[rsp_tid*3 +: 3] != 3'd3) |=> (drop_count == CNTW'($past(drop_count) + 1)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
endmodule

bind icl_line_req icl_line_req_chk #(
  .NTHR(NTHR), .AW(AW), .BLK_BYTES(BLK_BYTES), .RIDW(RIDW), .CNTW(CNTW)
) u_chk (.*);

// File: tb/icl_line_req_tb.sv
module icl_line_req_tb;
  localparam int NTHR = 2, AW = 12, BLK = 8, RIDW = 2, CNTW = 8, TIDW = 1, LW = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 0; logic [TIDW-1:0] fetch_tid = 0; logic [AW-1:0] fetch_pc = 0;
  logic [NTHR-1:0] stall = 0;
  logic squash_valid = 0; logic [TIDW-1:0] squash_tid = 0;
  logic req_valid; logic [TIDW-1:0] req_tid; logic [AW-1:0] req_addr; logic [RIDW-1:0] req_rid;
  logic req_grant = 0, retry_in = 0;
  logic rsp_valid = 0; logic [TIDW-1:0] rsp_tid = 0; logic [RIDW-1:0] rsp_rid = 0;
  logic [LW-1:0] rsp_data = 0;
  logic hit_valid; logic [TIDW-1:0] hit_tid; logic [LW-1:0] hit_line;
  logic cache_blocked; logic [CNTW-1:0] drop_count;
  logic [3*NTHR-1:0] thr_state; logic [NTHR-1:0] line_valid;

  always #2.5 clk = ~clk;

  icl_line_req #(.NTHR(NTHR), .AW(AW), .BLK_BYTES(BLK), .RIDW(RIDW), .CNTW(CNTW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [RIDW-1:0] rid_e [NTHR];
  logic [CNTW-1:0] drop_e = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [2:0] st(input int t);
    return thr_state[3*t +: 3];
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic issue(input int t, input logic [AW-1:0] pc);
    fetch_valid = 1; fetch_tid = TIDW'(t); fetch_pc = pc;
    tick(); fetch_valid = 0;
    chk("R1", "req_valid", req_valid, 1);
    chk("R1", "req_addr", req_addr, (pc / BLK) * BLK);
    chk("R3", "req_tid", req_tid, t);
    chk("R3", "req_rid", req_rid, rid_e[t]);
    chk("R3", "state send", st(t), 1);
    chk("R3", "line cleared", line_valid[t], 0);
    rid_e[t] = rid_e[t] + 1'b1;
  endtask

  task automatic grant(input logic g);
    req_grant = g; tick(); req_grant = 0;
    chk("R10", "req pulse", req_valid, 0);
  endtask

  task automatic respond(input int t, input logic [RIDW-1:0] rid, input logic [LW-1:0] d);
    rsp_valid = 1; rsp_tid = TIDW'(t); rsp_rid = rid; rsp_data = d;
    tick(); rsp_valid = 0;
  endtask

  task automatic squash(input int t);
    squash_valid = 1; squash_tid = TIDW'(t); tick(); squash_valid = 0;
  endtask

  task automatic fill(input int t, input logic [AW-1:0] pc, input logic [LW-1:0] d);
    issue(t, pc);
    grant(1);
    chk("R6", "state wait rsp", st(t), 3);
    respond(t, rid_e[t] - 1'b1, d);
    chk("R8", "state done", st(t), 4);
    chk("R8", "line valid", line_valid[t], 1);
    tick();
    chk("R8", "back to run", st(t), 0);
  endtask

  task automatic hit_sweep(input int t, input logic [AW-1:0] base, input logic [LW-1:0] d);
    for (int off = 0; off < BLK; off++) begin
      fetch_valid = 1; fetch_tid = TIDW'(t); fetch_pc = base + AW'(off);
      tick();
      chk("R2", "hit_valid", hit_valid, 1);
      chk("R2", "hit_tid", hit_tid, t);
      chk("R2", "hit_line", hit_line, d);
      chk("R2", "no request", req_valid, 0);
    end
    fetch_valid = 0;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [LW-1:0] d1_last;
    d1_last = '0;
    rid_e[0] = 0; rid_e[1] = 0;
    tick(); tick(); tick();
    rst = 0;
    tick();
    chk("R3", "reset req", req_valid, 0);
    chk("R3", "reset blocked", cache_blocked, 0);
    chk("R3", "reset states", thr_state, 0);
    chk("R3", "reset lines", line_valid, 0);
    chk("R3", "reset drops", drop_count, 0);

    // Sweep blocks per thread: fill then hit on every byte offset
    for (int t = 0; t < NTHR; t++) begin
      for (int k = 0; k < 4; k++) begin
        int b;
        logic [LW-1:0] d;
        b = (k == 0) ? 0 : (k == 1) ? 37 : (k == 2) ? 300 : 511;
        d = 64'hA5A5_0000_0000_0000 ^ (64'(t) << 40) ^ (64'(b) * 64'h0001_0001);
        fill(t, AW'(b * BLK + (b % BLK)), d);
        hit_sweep(t, AW'(b * BLK), d);
        if (t == 1) d1_last = d;
      end
    end

    // Stale identifier, then stray response to a running thread
    issue(0, 12'h100);
    grant(1);
    respond(0, rid_e[0] - 2'd2, 64'hDEAD);
    drop_e++;
    chk("R7", "drop count", drop_count, drop_e);
    chk("R7", "still waiting", st(0), 3);
    chk("R7", "line untouched", line_valid[0], 0);
    respond(0, rid_e[0] - 1'b1, 64'h1111);
    chk("R8", "accepted", st(0), 4);
    tick();
    respond(1, rid_e[1] - 1'b1, 64'hBAD);
    drop_e++;
    chk("R7", "stray drop", drop_count, drop_e);
    hit_sweep(1, 12'd511 * BLK, d1_last);

    // Refusal, blocking, retry
    issue(0, 12'h20B);
    grant(0);
    chk("R4", "blocked", cache_blocked, 1);
    chk("R4", "wait retry", st(0), 2);
    fetch_valid = 1; fetch_tid = 1; fetch_pc = 12'h300;
    tick(); fetch_valid = 0;
    chk("R5", "no new req", req_valid, 0);
    chk("R5", "other thread idle", st(1), 0);
    retry_in = 1; tick(); retry_in = 0;
    chk("R6", "resend", req_valid, 1);
    chk("R6", "resend tid", req_tid, 0);
    chk("R6", "resend addr", req_addr, 12'h208);
    chk("R6", "resend rid", req_rid, rid_e[0] - 1'b1);
    grant(1);
    chk("R6", "unblocked", cache_blocked, 0);
    chk("R6", "wait rsp", st(0), 3);
    respond(0, rid_e[0] - 1'b1, 64'h2222);
    chk("R8", "done", st(0), 4);
    tick();

    // Squash ownership of the retry slot
    issue(0, 12'h400);
    grant(0);
    squash(1);
    chk("R9", "foreign squash keeps block", cache_blocked, 1);
    chk("R9", "parked thread kept", st(0), 2);
    squash(0);
    chk("R9", "own squash unblocks", cache_blocked, 0);
    chk("R9", "squashed to run", st(0), 0);
    fill(1, 12'h500, 64'h3333);

    // Squash while waiting for a response
    issue(1, 12'h600);
    grant(1);
    squash(1);
    chk("R9", "squash forgets", st(1), 0);
    respond(1, rid_e[1] - 1'b1, 64'h4444);
    drop_e++;
    chk("R9", "late rsp dropped", drop_count, drop_e);
    chk("R9", "line not filled", line_valid[1], 0);

    // Stall handling
    stall[0] = 1; tick();
    chk("R11", "run stalls", st(0), 5);
    stall[0] = 0; tick();
    chk("R11", "unstall", st(0), 0);
    issue(0, 12'h700);
    grant(1);
    stall[0] = 1;
    respond(0, rid_e[0] - 1'b1, 64'h5555);
    chk("R8", "fill while stalled", st(0), 5);
    chk("R8", "line valid stalled", line_valid[0], 1);
    stall[0] = 0; tick();
    chk("R11", "release", st(0), 0);
    hit_sweep(0, 12'h700, 64'h5555);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule